// File: doc/BRIEF.md
# Chained-Descriptor Packet Transmit DMA

This block walks a ring of transmit descriptors held in system memory and turns the buffers they point at into an outgoing byte stream for a serial link transmitter. Each descriptor names a word-aligned buffer and carries a flag word. The flag word gives the byte count and says whether the packet ends after this chunk. It also says whether a CRC is inserted at this point, and which CRC kind. Buffer words are read through a 32-bit memory read/write master into a small word FIFO. A serializer then sends them out one byte at a time. After the last chunk of a packet it sends an end-of-packet marker token. Several descriptors can form one packet, and the running CRC carries from one chunk to the next until it is inserted.

Software sets up the ring base, the interrupt spacing and the mode through a four-word register port, then starts the walker. In single-shot mode the walker stops at the first descriptor whose valid bit is clear and raises an interrupt. In continuous mode it raises an interrupt after every programmed number of finished descriptors and never halts on its own. At an invalid descriptor it re-reads that descriptor until software fills it in. It stops only when software clears the run bit. After each descriptor is consumed, the walker writes its flag word back with the valid bit cleared.

Top module: `txchain_dma`

## Requirements
- R1: After reset, tx_valid, mem_req and irq are low and the status register (address 3) reads zero. While the walker is idle, no memory request and no output token is issued.
- R2: Descriptor i sits at byte address BASE + 8*i, where BASE is the 8-aligned value at register address 1 and i wraps at RING_LEN. Word 0 is the word-aligned buffer address. Word 1 is the flag word: bits 15:0 byte count, bit 16 end of packet, bit 17 header CRC, bit 18 data CRC, bit 19 CRC-16 (CRC-8 when clear), bit 31 valid. A memory request holds its address, direction and data until mem_ack.
- R3: The bytes of a buffer are emitted in address order, least significant byte lane of each word first. Exactly the byte count is emitted, and the FIFO is never pushed while full.
- R4: Chunks without bit 16 are joined into one packet. A marker token (tx_eop high) follows only a chunk with bit 16 set.
- R5: When bit 17 or bit 18 is set and bit 19 is clear, one CRC-8 byte follows the chunk's data. The CRC-8 uses x^8+x^2+x+1, processes bits least significant first, and starts from zero. It covers every byte since the last CRC insertion or marker, across chunk boundaries.
- R6: When bit 19 is also set, a CRC-16 follows instead, high byte first. The CRC-16 uses polynomial 0x1021, processes bits most significant first, starts from 0xFFFF, and restarts after each insertion.
- R7: When a descriptor is finished, its word 1 is rewritten with bit 31 cleared and all other bits kept, and word 0 is left untouched.
- R8: In single-shot mode (control bit 1 clear), reaching a descriptor with bit 31 clear ends the run. irq rises and status bit 0 (busy) falls.
- R9: In continuous mode (control bit 1 set), irq rises after every N finished descriptors, where N is register address 2, and the run goes on. An invalid descriptor is polled until it becomes valid, and writing control bit 0 as zero ends the run without an interrupt.
- R10: A zero-length descriptor emits no data bytes. With bit 16 set it emits only the pending CRC (if its CRC flag is set) and the marker.
- R11: Writing 1 to status bit 1 (address 3) clears irq.
- R12: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_eop hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select: 0 control, 1 ring base, 2 interrupt spacing, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory transfer complete; read data valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Output token available |
| tx_ready | input | 1 | Link side accepts the token |
| tx_data | output | 8 | Data byte of the token |
| tx_eop | output | 1 | Token is an end-of-packet marker |
| irq | output | 1 | Interrupt request, level |

## Verification
A register write takes effect at the clock edge that samples it, and status reads are combinational, so the bench reads them one step after a write. The byte stream is not checked at a fixed latency, because each chunk waits on two descriptor reads and one memory access per word. Instead, a monitor on the falling edge logs every accepted token in order. Each scenario then waits, under a cycle limit, for irq or for the busy bit to change, and compares the whole log against a stream built from the requirements. In that same falling-edge step the monitor checks that a stalled token is still present and unchanged on the next cycle. Writeback is checked by reading the bench memory after the run has finished.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int FL_EOP   = 16;
  localparam int FL_HCRC  = 17;
  localparam int FL_DCRC  = 18;
  localparam int FL_WIDE  = 19;
  localparam int FL_VALID = 31;

  typedef enum logic [2:0] {
    W_IDLE, W_RD0, W_RD1, W_FETCH, W_DRAIN, W_WB
  } walk_st_t;

  typedef enum logic [1:0] {
    S_IDLE, S_DATA, S_CRC, S_MARK
  } ser_st_t;

  // one byte through the reflected 8-bit CRC, bit by bit
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 8'hE0;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // one byte through the 16-bit CRC, top bit first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction
endpackage

// File: rtl/txd_fifo.sv
module txd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign dout  = store[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        store[wp] <= din;
        wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end
endmodule

// File: rtl/txd_crc.sv
module txd_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [7:0]  crc8,
  output logic [15:0] crc16
);
  import txd_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      crc8  <= 8'h00;
      crc16 <= 16'hFFFF;
    end else if (en) begin
      crc8  <= crc8_step(crc8, din);
      crc16 <= crc16_step(crc16, din);
    end
  end
endmodule

// File: rtl/txd_serializer.sv
module txd_serializer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] s_len,
  input  logic             s_eop,
  input  logic             s_crc,
  input  logic             s_wide,
  input  logic [31:0]      fifo_dout,
  input  logic             fifo_empty,
  output logic             fifo_pop,
  input  logic [7:0]       crc8,
  input  logic [15:0]      crc16,
  output logic             crc_en,
  output logic             crc_clr,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_eop,
  input  logic             tx_ready,
  output logic             chunk_done
);
  import txd_pkg::*;

  ser_st_t          st;
  logic [LEN_W-1:0] rem;
  logic [1:0]       lane;
  logic             eop_r, crc_r, wide_r, cidx;
  logic             fire, crc_last;

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    case (st)
      S_DATA: begin
        tx_valid = !fifo_empty;
        tx_data  = fifo_dout[8*lane +: 8];
      end
      S_CRC: begin
        tx_valid = 1'b1;
        tx_data  = wide_r ? (cidx ? crc16[7:0] : crc16[15:8]) : crc8;
      end
      S_MARK: tx_valid = 1'b1;
      default: ;
    endcase
  end

  assign tx_eop   = (st == S_MARK);
  assign fire     = tx_valid && tx_ready;
  assign crc_last = !wide_r || cidx;
  assign crc_en   = fire && (st == S_DATA);
  assign fifo_pop = crc_en && (lane == 2'd3 || rem == LEN_W'(1));
  assign crc_clr  = fire && ((st == S_CRC && crc_last) || st == S_MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      rem        <= '0;
      lane       <= '0;
      eop_r      <= 1'b0;
      crc_r      <= 1'b0;
      wide_r     <= 1'b0;
      cidx       <= 1'b0;
      chunk_done <= 1'b0;
    end else begin
      chunk_done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rem    <= s_len;
          lane   <= '0;
          eop_r  <= s_eop;
          crc_r  <= s_crc;
          wide_r <= s_wide;
          cidx   <= 1'b0;
          if (s_len != '0)  st <= S_DATA;
          else if (s_crc)   st <= S_CRC;
          else if (s_eop)   st <= S_MARK;
          else              chunk_done <= 1'b1;
        end
        S_DATA: if (fire) begin
          lane <= lane + 2'd1;
          rem  <= rem - 1'b1;
          if (rem == LEN_W'(1)) begin
            if (crc_r)      st <= S_CRC;
            else if (eop_r) st <= S_MARK;
            else begin
              st         <= S_IDLE;
              chunk_done <= 1'b1;
            end
          end
        end
        S_CRC: if (fire) begin
          if (!crc_last)  cidx <= 1'b1;
          else if (eop_r) st <= S_MARK;
          else begin
            st         <= S_IDLE;
            chunk_done <= 1'b1;
          end
        end
        S_MARK: if (fire) begin
          st         <= S_IDLE;
          chunk_done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_walker.sv
module txd_walker #(
  parameter int LEN_W    = 16,
  parameter int RING_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             cont,
  input  logic [31:0]      base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             fifo_push,
  input  logic             fifo_full,
  output logic             chunk_start,
  output logic [31:0]      flags,
  input  logic             chunk_done,
  output logic             desc_done,
  output logic             list_end,
  output logic             busy
);
  import txd_pkg::*;

  localparam int IW = (RING_LEN > 1) ? $clog2(RING_LEN) : 1;

  walk_st_t         st;
  logic [IW-1:0]    idx;
  logic [31:0]      buf_addr, desc_addr;
  logic [LEN_W-1:0] words_left;
  logic             done_seen;
  walk_st_t         after_desc;

  assign desc_addr  = base + {{(29-IW){1'b0}}, idx, 3'b000};
  assign after_desc = run ? W_RD0 : W_IDLE;
  assign busy       = (st != W_IDLE);
  assign mem_we     = (st == W_WB);
  assign mem_wdata  = flags & ~(32'd1 << FL_VALID);
  assign fifo_push  = (st == W_FETCH) && mem_ack;

  always_comb begin
    mem_req  = 1'b0;
    mem_addr = desc_addr;
    case (st)
      W_RD0:   mem_req = 1'b1;
      W_RD1, W_WB: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + 32'd4;
      end
      W_FETCH: begin
        mem_req  = (words_left != '0) && !fifo_full;
        mem_addr = buf_addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= W_IDLE;
      idx         <= '0;
      buf_addr    <= '0;
      flags       <= '0;
      words_left  <= '0;
      done_seen   <= 1'b0;
      chunk_start <= 1'b0;
      desc_done   <= 1'b0;
      list_end    <= 1'b0;
    end else begin
      chunk_start <= 1'b0;
      desc_done   <= 1'b0;
      list_end    <= 1'b0;
      if (chunk_done) done_seen <= 1'b1;
      case (st)
        W_IDLE: if (start) begin
          idx <= '0;
          st  <= W_RD0;
        end
        W_RD0: if (mem_ack) begin
          buf_addr <= mem_rdata;
          st       <= W_RD1;
        end
        W_RD1: if (mem_ack) begin
          flags <= mem_rdata;
          if (!mem_rdata[FL_VALID]) begin
            if (cont) st <= after_desc;
            else begin
              st       <= W_IDLE;
              list_end <= 1'b1;
            end
          end else begin
            chunk_start <= 1'b1;
            done_seen   <= 1'b0;
            words_left  <= LEN_W'(({1'b0, mem_rdata[LEN_W-1:0]} + 3) >> 2);
            st          <= W_FETCH;
          end
        end
        W_FETCH: begin
          if (words_left == '0) st <= W_DRAIN;
          else if (mem_ack) begin
            buf_addr   <= buf_addr + 32'd4;
            words_left <= words_left - 1'b1;
            if (words_left == LEN_W'(1)) st <= W_DRAIN;
          end
        end
        W_DRAIN: if (chunk_done || done_seen) st <= W_WB;
        W_WB: if (mem_ack) begin
          desc_done <= 1'b1;
          idx       <= (idx == IW'(RING_LEN-1)) ? '0 : idx + 1'b1;
          st        <= after_desc;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txchain_dma.sv
module txchain_dma #(
  parameter int LEN_W      = 16,
  parameter int RING_LEN   = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_eop,
  output logic        irq
);
  import txd_pkg::*;

  logic        run_r, cont_r;
  logic [31:0] base_r;
  logic [15:0] every_r, done_cnt;
  logic        busy, start_go;
  logic        fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [31:0] fifo_dout, flags;
  logic        chunk_start, chunk_done, desc_done, list_end;
  logic        crc_en, crc_clr_ser;
  logic [7:0]  crc8;
  logic [15:0] crc16;
  logic        irq_clr_wr;

  assign start_go   = reg_wr && reg_addr == 2'd0 && reg_wdata[0] && !busy;
  assign irq_clr_wr = reg_wr && reg_addr == 2'd3 && reg_wdata[1];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {30'd0, cont_r, run_r};
      2'd1:    reg_rdata = base_r;
      2'd2:    reg_rdata = {16'd0, every_r};
      default: reg_rdata = {30'd0, irq, busy};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_r    <= 1'b0;
      cont_r   <= 1'b0;
      base_r   <= '0;
      every_r  <= 16'd1;
      done_cnt <= '0;
      irq      <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd1) base_r  <= reg_wdata;
      if (reg_wr && reg_addr == 2'd2) every_r <= reg_wdata[15:0];
      if (reg_wr && reg_addr == 2'd0 && !reg_wdata[0]) run_r <= 1'b0;
      if (irq_clr_wr) irq <= 1'b0;
      if (start_go) begin
        run_r    <= 1'b1;
        cont_r   <= reg_wdata[1];
        done_cnt <= '0;
      end else if (desc_done && cont_r) begin
        if (done_cnt + 16'd1 >= every_r) begin
          done_cnt <= '0;
          irq      <= 1'b1;
        end else begin
          done_cnt <= done_cnt + 16'd1;
        end
      end
      if (list_end) begin
        irq   <= 1'b1;
        run_r <= 1'b0;
      end
    end
  end

  txd_walker #(.LEN_W(LEN_W), .RING_LEN(RING_LEN)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_go), .run(run_r), .cont(cont_r),
    .base(base_r), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fifo_push(fifo_push), .fifo_full(fifo_full), .chunk_start(chunk_start),
    .flags(flags), .chunk_done(chunk_done), .desc_done(desc_done),
    .list_end(list_end), .busy(busy)
  );

  txd_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(mem_rdata),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
  );

  txd_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr_ser || start_go), .en(crc_en),
    .din(tx_data), .crc8(crc8), .crc16(crc16)
  );

  txd_serializer #(.LEN_W(LEN_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(chunk_start), .s_len(flags[LEN_W-1:0]),
    .s_eop(flags[FL_EOP]), .s_crc(flags[FL_HCRC] | flags[FL_DCRC]),
    .s_wide(flags[FL_WIDE]), .fifo_dout(fifo_dout), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .crc8(crc8), .crc16(crc16), .crc_en(crc_en),
    .crc_clr(crc_clr_ser), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_eop(tx_eop), .tx_ready(tx_ready), .chunk_done(chunk_done)
  );
endmodule

// File: rtl/txchain_dma_checker.sv
module txchain_dma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_eop,
  input logic        irq,
  input logic        busy,
  input logic        fifo_push,
  input logic        fifo_full,
  input logic        list_end
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid));

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r7_wb_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (!mem_wdata[31] && mem_addr[2]));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);

  a_r8_end_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    list_end |=> (irq && !busy));

  a_r12_hold_token: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eop)));
endmodule

bind txchain_dma txchain_dma_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_eop(tx_eop), .irq(irq), .busy(busy), .fifo_push(fifo_push),
  .fifo_full(fifo_full), .list_end(list_end)
);

// File: tb/txchain_dma_tb.sv
`timescale 1ns/1ps
module txchain_dma_tb;
  localparam int DBASE = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_eop, irq;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  always #2.5 clk = ~clk;

  txchain_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_eop(tx_eop), .irq(irq)
  );

  // memory model, one-cycle acknowledge; host writes go through hw_*
  logic [31:0] mem [0:255];
  logic        hw_en = 1'b0;
  logic [7:0]  hw_a = '0;
  logic [31:0] hw_d = '0;
  always @(posedge clk) begin
    if (hw_en) mem[hw_a] <= hw_d;
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end else mem_ack <= 1'b0;
  end

  // token monitor with optional backpressure
  logic [8:0]  cap [0:255];
  int          ncap = 0;
  int          bp_err = 0;
  logic        bp = 1'b0;
  logic [4:0]  lfsr = 5'h13;
  logic        prev_stall = 1'b0;
  logic [8:0]  prev_tok = '0;
  always @(negedge clk) begin
    logic rv;
    rv = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
    lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
    tx_ready = rv;
    if (prev_stall && !(tx_valid && {tx_eop, tx_data} == prev_tok)) bp_err++;
    prev_stall = tx_valid && !rv;
    prev_tok = {tx_eop, tx_data};
    if (tx_valid && rv) begin
      cap[ncap] = {tx_eop, tx_data};
      ncap++;
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected stream built from the requirements
  logic [8:0]  exp_tok [0:255];
  int          nexp = 0;
  logic [7:0]  rc8 = 8'h00;
  logic [15:0] rc16 = 16'hFFFF;

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed * 29 + k * 7 + 3);
  endfunction

  function automatic logic [7:0] ref8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    repeat (8) x = x[0] ? ((x >> 1) ^ 8'hE0) : (x >> 1);
    return x;
  endfunction

  function automatic logic [15:0] ref16(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c ^ {d, 8'h00};
    repeat (8) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  task automatic poke(input int word, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_a = 8'(word); hw_d = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_desc(input int i, input logic [31:0] ba, input logic [31:0] fl);
    poke(DBASE/4 + 2*i, ba);
    poke(DBASE/4 + 2*i + 1, fl);
  endtask

  // writes buffer and descriptor i, extends the expected stream
  task automatic add_chunk(input int i, input int ba, input int len,
                           input logic [31:0] fbits, input int seed);
    for (int w = 0; w < (len + 3) / 4; w++)
      poke(ba/4 + w, {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
    for (int k = 0; k < len; k++) begin
      exp_tok[nexp] = {1'b0, pat(seed, k)}; nexp++;
      rc8 = ref8(rc8, pat(seed, k));
      rc16 = ref16(rc16, pat(seed, k));
    end
    if (fbits[17] || fbits[18]) begin
      if (fbits[19]) begin
        exp_tok[nexp] = {1'b0, rc16[15:8]}; nexp++;
        exp_tok[nexp] = {1'b0, rc16[7:0]};  nexp++;
      end else begin
        exp_tok[nexp] = {1'b0, rc8}; nexp++;
      end
      rc8 = 8'h00; rc16 = 16'hFFFF;
    end
    if (fbits[16]) begin
      exp_tok[nexp] = 9'h100; nexp++;
      rc8 = 8'h00; rc16 = 16'hFFFF;
    end
    set_desc(i, ba, fbits | 32'h8000_0000 | 32'(len));
  endtask

  task automatic begin_expect();
    nexp = 0; rc8 = 8'h00; rc16 = 16'hFFFF;
  endtask

  task automatic wait_irq(input string tag, input int limit);
    int n;
    n = 0;
    while (irq !== 1'b1 && n < limit) begin @(negedge clk); n++; end
    chk({tag, " irq within limit"}, 32'(irq), 32'd1);
  endtask

  task automatic cmp_stream(input string tag, input int from);
    chk({tag, " token count"}, 32'(ncap - from), 32'(nexp));
    for (int k = 0; k < nexp; k++)
      if (cap[from + k] !== exp_tok[k]) begin
        checks++; errors++;
        $display("FAIL %s token %0d actual=%h expected=%h", tag, k, cap[from+k], exp_tok[k]);
      end
  endtask

  task automatic test_reset();
    logic [31:0] s;
    reg_read(2'd3, s);
    chk("R1 status", s, 32'd0);
    chk("R1 outputs", {29'd0, tx_valid, mem_req, irq}, 32'd0);
  endtask

  task automatic test_single();
    int from;
    logic [31:0] s;
    begin_expect();
    add_chunk(0, 32'h200, 5, 32'h0001_0000, 1);
    set_desc(1, 32'h0, 32'h0);
    from = ncap;
    reg_write(2'd0, 32'd1);
    wait_irq("R8 single", 2000);
    reg_read(2'd3, s);
    chk("R8 busy low at end", s & 32'd1, 32'd0);
    cmp_stream("R3 R4 single chunk", from);
    chk("R7 flag word cleared", mem[DBASE/4 + 1], 32'h0001_0005);
    chk("R2 word0 kept", mem[DBASE/4], 32'h200);
    reg_write(2'd3, 32'd2);
    chk("R11 irq cleared", 32'(irq), 32'd0);
  endtask

  task automatic test_chain_crc8();
    int from;
    begin_expect();
    add_chunk(0, 32'h200, 3, 32'h0, 2);
    add_chunk(1, 32'h240, 4, 32'h0, 3);
    add_chunk(2, 32'h280, 2, 32'h0005_0000, 4);
    set_desc(3, 32'h0, 32'h0);
    bp = 1'b1;
    from = ncap;
    reg_write(2'd0, 32'd1);
    wait_irq("R5 chain", 4000);
    bp = 1'b0;
    cmp_stream("R4 R5 chained CRC-8", from);
    chk("R12 stalled tokens held", 32'(bp_err), 32'd0);
    reg_write(2'd3, 32'd2);
  endtask

  task automatic test_crc16();
    int from;
    begin_expect();
    add_chunk(0, 32'h200, 4, 32'h000A_0000, 5);
    add_chunk(1, 32'h240, 6, 32'h000D_0000, 6);
    set_desc(2, 32'h0, 32'h0);
    from = ncap;
    reg_write(2'd0, 32'd1);
    wait_irq("R6 crc16", 3000);
    cmp_stream("R6 header and data CRC-16", from);
    reg_write(2'd3, 32'd2);
  endtask

  task automatic test_zero_len();
    int from;
    begin_expect();
    add_chunk(0, 32'h200, 3, 32'h0, 7);
    add_chunk(1, 32'h240, 0, 32'h0005_0000, 8);
    add_chunk(2, 32'h280, 0, 32'h0001_0000, 9);
    set_desc(3, 32'h0, 32'h0);
    from = ncap;
    reg_write(2'd0, 32'd1);
    wait_irq("R10 zero", 3000);
    cmp_stream("R10 zero-length chunks", from);
    reg_write(2'd3, 32'd2);
  endtask

  task automatic test_continuous();
    int from, mid;
    logic [31:0] s;
    begin_expect();
    reg_write(2'd2, 32'd2);
    add_chunk(0, 32'h200, 2, 32'h0001_0000, 10);
    add_chunk(1, 32'h240, 2, 32'h0001_0000, 11);
    set_desc(2, 32'h0, 32'h0);
    from = ncap;
    reg_write(2'd0, 32'd3);
    wait_irq("R9 first batch", 3000);
    reg_read(2'd3, s);
    chk("R9 still busy after interrupt", s & 32'd1, 32'd1);
    cmp_stream("R9 first batch stream", from);
    reg_write(2'd3, 32'd2);
    repeat (60) @(negedge clk);
    chk("R9 polling emits nothing", 32'(ncap - from), 32'(nexp));
    chk("R9 no irq while polling", 32'(irq), 32'd0);
    mid = ncap;
    begin_expect();
    add_chunk(3, 32'h2C0, 3, 32'h0001_0000, 13);
    set_desc(4, 32'h0, 32'h0);
    begin_expect();
    add_chunk(2, 32'h280, 5, 32'h0005_0000, 12);
    // rebuild full expectation in walk order: descriptor 2 then 3
    exp_tok[nexp] = {1'b0, pat(13, 0)}; nexp++;
    exp_tok[nexp] = {1'b0, pat(13, 1)}; nexp++;
    exp_tok[nexp] = {1'b0, pat(13, 2)}; nexp++;
    exp_tok[nexp] = 9'h100; nexp++;
    wait_irq("R9 second batch", 3000);
    cmp_stream("R9 refilled descriptors", mid);
    reg_write(2'd3, 32'd2);
    reg_write(2'd0, 32'd0);
    repeat (20) @(negedge clk);
    reg_read(2'd3, s);
    chk("R9 stop ends run quietly", s, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    reg_write(2'd1, DBASE);
    test_single();
    test_chain_crc8();
    test_crc16();
    test_zero_len();
    test_continuous();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule